// File: doc/BRIEF.md
# Write-Twice Cycle-Count Interrupt Timer

This block is a down-counter that decrements once per CPU clock cycle and raises an interrupt when it runs past zero. Software sets the count through one byte-wide load register, written twice in a row. The first write goes to the upper byte of the running count and the second write goes to the lower byte. A load changes the live count at once; no separate reload value is kept.

A second register, the control register, holds one enable bit. When that bit is set the count decrements by one on every cycle. When the count steps from zero to all-ones, the block latches an interrupt request and clears its own enable. After that the count stays at all-ones until software loads or re-enables it. Any write to the control register does two more things: it clears a pending interrupt, and it returns the byte pointer so that the next load write goes to the upper byte again.

Address decoding sits outside the block and arrives as two write strobes. Each strobe is a single-cycle event. The block has no back-pressure and no ready signal, so a strobe that is high on a rising clock edge always takes effect. The `count` output exposes the live count for test.

Top module: `cyc_irq_timer`

## Requirements
- R1: While `rst` is high on a clock edge, the count becomes 0, `irq` becomes 0, the enable clears and the byte pointer selects the upper byte. After reset the count holds at 0 until a write arrives.
- R2: Load writes alternate between bytes. The first write after reset or after a control write replaces the upper byte (bits CNT_W-1..DATA_W), the next write replaces the lower byte (bits DATA_W-1..0), and the third write goes to the upper byte again.
- R3: A load write replaces only the addressed byte of the live count. The other byte keeps its current value; no reload value is involved.
- R4: A control write stores `wdata` bit EN_BIT (bit 4 by default) as the enable. While the enable is 1 and no load write occurs, the count drops by exactly one per cycle. While it is 0, the count holds.
- R5: On a cycle where the enable is 1, the count is 0 and there is no load write, the next edge sets the count to all-ones, sets `irq` and clears the enable. The count then holds at all-ones.
- R6: `irq` stays high until a control write, whatever value that write carries. The control write clears `irq` on the edge where it is taken.
- R7: A control write returns the byte pointer to the upper byte, even if it arrives between the two load writes.
- R8: A load write in a cycle where counting is enabled wins. The addressed byte takes `wdata`, the other byte is not decremented, and counting resumes from the new value on the following cycle.
- R9: If a control write and a wrap fall on the same edge, the wrap still sets `irq`. The enable takes the written bit instead of being cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU cycle clock |
| rst | input | 1 | Synchronous reset, active high |
| load_we | input | 1 | One-cycle write strobe for the byte-serial load register |
| ctrl_we | input | 1 | One-cycle write strobe for the control register |
| wdata | input | DATA_W | Write data shared by both registers |
| irq | output | 1 | Interrupt request, level, active high |
| count | output | 2*DATA_W | Live count value |

## Verification
The bench builds the block with DATA_W = 4 and EN_BIT = 2, which gives an 8-bit count whose full range costs only a few hundred cycles to run down. It can therefore load every one of the 256 start values through the two-write sequence, enable counting, and follow each value cycle by cycle through the wrap and the hold that follows. It also runs the collisions that a wide counter would hide: a load write against a running count, a control write landing between the two bytes, and a control write on the exact wrap edge.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // Which byte of the count the next load write replaces.
  typedef enum logic {
    PTR_HI = 1'b0,
    PTR_LO = 1'b1
  } byte_sel_e;
endpackage

// File: rtl/load_pointer.sv
module load_pointer
  import timer_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_we,
  input  logic ctrl_we,
  output logic ptr_lo
);
  byte_sel_e ptr_q;

  // A control write returns the pointer to the upper byte. It takes
  // priority over a load write in the same cycle; that load still uses
  // the pointer value it saw.
  always_ff @(posedge clk) begin
    if (rst)          ptr_q <= PTR_HI;
    else if (ctrl_we) ptr_q <= PTR_HI;
    else if (load_we) ptr_q <= (ptr_q == PTR_HI) ? PTR_LO : PTR_HI;
  end

  assign ptr_lo = (ptr_q == PTR_LO);
endmodule

// File: rtl/down_counter.sv
module down_counter #(
  parameter int DATA_W = 8,
  parameter int NBYTES = 2,
  localparam int CNT_W = NBYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_we,
  input  logic              ptr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              dec_en,
  output logic [CNT_W-1:0]  count,
  output logic              count_zero
);
  logic [CNT_W-1:0]  count_q;
  logic [CNT_W-1:0]  count_wr;
  logic [NBYTES-1:0] lane_wr;

  // One lane per byte. The low pointer addresses lane 0 and the high
  // pointer addresses the top lane; every other lane keeps its live value.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane_wr[g] = load_we && (ptr_lo ? (g == 0) : (g == NBYTES - 1));
    assign count_wr[g*DATA_W +: DATA_W] =
      lane_wr[g] ? wdata : count_q[g*DATA_W +: DATA_W];
  end

  // A load write wins over a decrement in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)          count_q <= '0;
    else if (load_we) count_q <= count_wr;
    else if (dec_en)  count_q <= count_q - CNT_W'(1);
  end

  assign count      = count_q;
  assign count_zero = (count_q == '0);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_we,
  input  logic en_wr,
  input  logic load_we,
  input  logic count_zero,
  output logic en_q,
  output logic irq_q,
  output logic dec_en
);
  logic wrap;

  // The counter steps past zero only when it actually decrements.
  assign wrap   = en_q && count_zero && !load_we;
  assign dec_en = en_q;

  // A written enable overrides the self-clear on a wrap.
  always_ff @(posedge clk) begin
    if (rst)          en_q <= 1'b0;
    else if (ctrl_we) en_q <= en_wr;
    else if (wrap)    en_q <= 1'b0;
  end

  // A wrap on the same edge as the acknowledge is never lost.
  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (wrap)    irq_q <= 1'b1;
    else if (ctrl_we) irq_q <= 1'b0;
  end
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int DATA_W = 8,
  parameter int EN_BIT = 4,
  localparam int NBYTES = 2,
  localparam int CNT_W  = NBYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_we,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] wdata,
  output logic              irq,
  output logic [CNT_W-1:0]  count
);
  logic ptr_lo;
  logic count_zero;
  logic dec_en;
  logic en_q;

  load_pointer u_ptr (
    .clk     (clk),
    .rst     (rst),
    .load_we (load_we),
    .ctrl_we (ctrl_we),
    .ptr_lo  (ptr_lo)
  );

  down_counter #(
    .DATA_W (DATA_W),
    .NBYTES (NBYTES)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_we    (load_we),
    .ptr_lo     (ptr_lo),
    .wdata      (wdata),
    .dec_en     (dec_en),
    .count      (count),
    .count_zero (count_zero)
  );

  irq_ctrl u_irq (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .en_wr      (wdata[EN_BIT]),
    .load_we    (load_we),
    .count_zero (count_zero),
    .en_q       (en_q),
    .irq_q      (irq),
    .dec_en     (dec_en)
  );
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
  parameter int DATA_W = 8,
  parameter int EN_BIT = 4,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst,
  input logic              load_we,
  input logic              ctrl_we,
  input logic [DATA_W-1:0] wdata,
  input logic              irq,
  input logic [CNT_W-1:0]  count,
  input logic              en_q,
  input logic              ptr_lo
);
  logic wrap_ev;
  assign wrap_ev = en_q && (count == '0) && !load_we;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count == '0) && !irq && !en_q && !ptr_lo);

  // R2
  first_byte_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (load_we && !ptr_lo && !ctrl_we) |=> ptr_lo);

  // R3
  hi_write_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (load_we && !ptr_lo) |=>
      (count[CNT_W-1:DATA_W] == $past(wdata)) &&
      (count[DATA_W-1:0] == $past(count[DATA_W-1:0])));

  // R4
  pause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !load_we) |=> $stable(count));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && !load_we && count != '0) |=> count == $past(count) - CNT_W'(1));

  // R5
  wrap_raise_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_ev |=> irq && (count == {CNT_W{1'b1}}));

  // R5
  wrap_disable_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_ev && !ctrl_we) |=> !en_q);

  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !ctrl_we) |=> irq);

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && !wrap_ev) |=> !irq);

  // R7
  ptr_rewind_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_we |=> !ptr_lo);

  // R9
  wrap_ack_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && wrap_ev) |=> irq && (en_q == $past(wdata[EN_BIT])));
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(
  .DATA_W (DATA_W),
  .EN_BIT (EN_BIT)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load_we (load_we),
  .ctrl_we (ctrl_we),
  .wdata   (wdata),
  .irq     (irq),
  .count   (count),
  .en_q    (en_q),
  .ptr_lo  (ptr_lo)
);

// File: tb/sim_cyc_irq_timer.sv
`timescale 1ns/1ps
module sim_cyc_irq_timer;
  localparam int DW   = 4;
  localparam int ENB  = 2;
  localparam int CW   = 2 * DW;
  localparam int MAXV = (1 << CW) - 1;
  localparam logic [DW-1:0] EN_ON  = DW'(1 << ENB);
  localparam logic [DW-1:0] EN_OFF = '0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_we = 1'b0;
  logic          ctrl_we = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          irq;
  logic [CW-1:0] count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cyc_irq_timer #(.DATA_W(DW), .EN_BIT(ENB)) u0 (
    .clk(clk), .rst(rst), .load_we(load_we), .ctrl_we(ctrl_we),
    .wdata(wdata), .irq(irq), .count(count)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected finish before 150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_load(input logic [DW-1:0] v);
    load_we = 1'b1; wdata = v;
    tick();
    load_we = 1'b0; wdata = '0;
  endtask

  task automatic wr_ctrl(input logic [DW-1:0] v);
    ctrl_we = 1'b1; wdata = v;
    tick();
    ctrl_we = 1'b0; wdata = '0;
  endtask

  initial begin
    int prev;
    int cur;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1: reset state, and the count holds at zero with no write
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);
    tick(); tick();
    chk("R1 hold", count, 0);

    // R2 R4 R5: sweep every start value through load, run-down and wrap
    prev = 0;
    for (int c = 0; c <= MAXV; c++) begin
      wr_ctrl(EN_OFF);
      chk("R6 ack", irq, 0);
      wr_load(DW'(c >> DW));
      chk("R2 upper first", count, ((c >> DW) << DW) | (prev & ((1 << DW) - 1)));
      wr_load(DW'(c));
      chk("R2 lower second", count, c);
      wr_ctrl(EN_ON);
      chk("R4 enable edge", count, c);
      for (int k = 1; k <= c + 3; k++) begin
        tick();
        if (k <= c) begin
          chk("R4 step", count, c - k);
          chk("R4 irq low", irq, 0);
        end else begin
          chk("R5 wrap count", count, MAXV);
          chk("R5 irq set", irq, 1);
        end
      end
      prev = MAXV;
    end

    // R6: irq held for many cycles, cleared by a control write with the enable bit set
    repeat (20) tick();
    chk("R6 held", irq, 1);
    wr_ctrl(EN_ON);
    chk("R6 ack any value", irq, 0);
    tick();
    chk("R5 re-enable from all-ones", count, MAXV - 1);
    wr_ctrl(EN_OFF);
    cur = count;
    repeat (5) tick();
    chk("R4 pause", count, cur);

    // R3 R7: third write goes high; control write between bytes rewinds
    wr_load(4'h3); wr_load(4'h9);
    chk("R2 pair", count, 8'h39);
    wr_load(4'h5);
    chk("R3 third write upper keeps lower", count, 8'h59);
    wr_ctrl(EN_OFF);
    wr_load(4'h7);
    chk("R7 rewind to upper", count, 8'h79);
    wr_load(4'h2);
    chk("R3 lower keeps upper", count, 8'h72);

    // R8: load writes against a running count
    wr_ctrl(EN_ON);
    tick(); tick();
    cur = count;
    chk("R8 running", cur, 8'h70);
    load_we = 1'b1; wdata = 4'hA;
    tick();
    load_we = 1'b0;
    chk("R8 upper wins no decrement", count, 8'hA0 | (cur & 4'hF));
    tick();
    chk("R8 resume", count, (8'hA0 | (cur & 4'hF)) - 1);
    cur = count;
    load_we = 1'b1; wdata = 4'h3;
    tick();
    load_we = 1'b0;
    chk("R8 lower wins no decrement", count, (cur & 8'hF0) | 3);

    // R9: control write on the exact wrap edge
    wr_ctrl(EN_OFF);
    wr_load(4'h0); wr_load(4'h0);
    wr_ctrl(EN_ON);
    chk("R9 setup", count, 0);
    wr_ctrl(EN_ON);
    chk("R9 irq kept", irq, 1);
    chk("R9 wrap count", count, MAXV);
    tick();
    chk("R9 enable from write", count, MAXV - 1);
    wr_ctrl(EN_OFF);
    wr_load(4'h0); wr_load(4'h0);
    wr_ctrl(EN_ON);
    wr_ctrl(EN_OFF);
    chk("R9 irq kept (off)", irq, 1);
    tick(); tick();
    chk("R9 disabled by write", count, MAXV);

    // R1: reset mid-run clears everything
    wr_ctrl(EN_ON);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset count", count, 0);
    chk("R1 reset irq", irq, 0);
    tick(); tick();
    chk("R1 reset enable off", count, 0);
    wr_load(4'h6);
    chk("R1 reset pointer upper", count, 8'h60);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule